// File: doc/BRIEF.md
# LED Strobe Channel Sequencer

This block drives the enable lines of a bank of LED channels, ten by default. In strobe mode an external PWM waveform both clocks and times the lighting. Each rising edge of the waveform moves a one-hot pointer to the next channel. The selected channel is enabled only while the waveform is high, so the waveform's duty cycle sets the on-time, and every other channel stays dark. When strobe mode is off, the block passes the per-channel enables from the normal dimming path straight to its outputs and holds the pointer idle.

The PWM input may be asynchronous to the block clock. It passes through a two-flop synchronizer and then a history flop that detects rising edges. Current regulation and analog control happen elsewhere; this block only produces the enable vector. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `led_strobe_sequencer`

## Requirements
- R1: After reset the pointer is idle, so in strobe mode no channel is enabled until the first synchronized rising edge of the PWM input.
- R2: When the PWM input is first sampled high at a clock edge, with strobe mode on, the newly selected channel's output goes high after the third rising clock edge, counting that first edge.
- R3: Each rising edge of the PWM input in strobe mode advances the pointer by one channel in ascending order. Output bit i enables channel i.
- R4: A rising edge with channel NUM_CH-1 selected wraps the pointer back to channel 0.
- R5: In strobe mode at most one output bit is high at any time.
- R6: The selected channel stays enabled only while the synchronized PWM input is high. It drops after the third clock edge that samples the input low.
- R7: With strobe mode off, the output equals the normal enable vector in the same cycle.
- R8: With strobe mode off, the pointer returns to idle and rising edges are ignored. After strobe mode is re-entered, the first rising edge selects channel 0. A rising edge detected in the same cycle that strobe mode turns on counts as that first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_en_i | input | 1 | Strobe mode select (1 = strobe, 0 = pass-through) |
| pwm_i | input | 1 | External PWM waveform, asynchronous |
| normal_en_i | input | NUM_CH | Per-channel enables used when strobe mode is off |
| chan_en_o | output | NUM_CH | Channel enable vector, bit i for channel i |

## Verification
The pointer update and the mode switch can act in the same clock cycle. This happens when a synchronized PWM rising edge is detected in the cycle where strobe mode turns on or off. The bench provokes it by raising the PWM input two clock cycles before it changes the mode bit. The edge must then select channel 0 on entry and be dropped on exit. A behavioural reference model, compared on every clock, also judges the wrap after the last channel, single-cycle PWM pulses, and mode exits in the middle of a lit pulse.

// File: rtl/strobe_pkg.sv
`timescale 1ns/1ps
package strobe_pkg;
  localparam int unsigned DEF_CHANNELS    = 10;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_RST_STAGES  = 2;
endpackage

// File: rtl/strobe_rst_sync.sv
`timescale 1ns/1ps
module strobe_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/strobe_edge_detect.sv
`timescale 1ns/1ps
module strobe_edge_detect #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic rise_o,
  output logic level_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   synced;
  logic                   hist_q;
  logic                   hist_d;

  assign synced = sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pwm_i};
    hist_d = synced;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      hist_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
    end
  end

  assign rise_o  = synced & ~hist_q;
  assign level_o = hist_q;
endmodule

// File: rtl/strobe_ring.sv
`timescale 1ns/1ps
module strobe_ring #(
  parameter int unsigned CHANNELS = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                step_i,
  output logic [CHANNELS-1:0] ptr_o
);
  localparam logic [CHANNELS-1:0] FIRST = {{(CHANNELS-1){1'b0}}, 1'b1};

  logic [CHANNELS-1:0] ptr_q;
  logic [CHANNELS-1:0] ptr_d;
  logic                ptr_en;

  always_comb begin
    ptr_en = !run_i || step_i;
    ptr_d  = ptr_q;
    if (!run_i) begin
      ptr_d = '0;
    end else if (step_i) begin
      if (ptr_q == '0) ptr_d = FIRST;
      else             ptr_d = {ptr_q[CHANNELS-2:0], ptr_q[CHANNELS-1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/strobe_out_select.sv
`timescale 1ns/1ps
module strobe_out_select #(
  parameter int unsigned CHANNELS = 10
) (
  input  logic                strobe_i,
  input  logic                level_i,
  input  logic [CHANNELS-1:0] ptr_i,
  input  logic [CHANNELS-1:0] normal_i,
  output logic [CHANNELS-1:0] en_o
);
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    assign en_o[ch] = strobe_i ? (ptr_i[ch] & level_i) : normal_i[ch];
  end
endmodule

// File: rtl/led_strobe_sequencer.sv
`timescale 1ns/1ps
module led_strobe_sequencer #(
  parameter int unsigned NUM_CH      = strobe_pkg::DEF_CHANNELS,
  parameter int unsigned SYNC_STAGES = strobe_pkg::DEF_SYNC_STAGES,
  parameter int unsigned RST_STAGES  = strobe_pkg::DEF_RST_STAGES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_en_i,
  input  logic              pwm_i,
  input  logic [NUM_CH-1:0] normal_en_i,
  output logic [NUM_CH-1:0] chan_en_o
);
  logic              rst_int_n;
  logic              rise;
  logic              pwm_level;
  logic [NUM_CH-1:0] ptr_q;

  strobe_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_int_n)
  );

  strobe_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .pwm_i   (pwm_i),
    .rise_o  (rise),
    .level_o (pwm_level)
  );

  strobe_ring #(.CHANNELS(NUM_CH)) u_ring (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .run_i  (strobe_en_i),
    .step_i (rise),
    .ptr_o  (ptr_q)
  );

  strobe_out_select #(.CHANNELS(NUM_CH)) u_sel (
    .strobe_i (strobe_en_i),
    .level_i  (pwm_level),
    .ptr_i    (ptr_q),
    .normal_i (normal_en_i),
    .en_o     (chan_en_o)
  );
endmodule

// File: rtl/strobe_checker.sv
`timescale 1ns/1ps
module strobe_checker #(
  parameter int unsigned N = 10
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         strobe_en_i,
  input logic         rise_i,
  input logic         level_i,
  input logic [N-1:0] ptr_i,
  input logic [N-1:0] chan_en_i
);
  // R5: pointer never selects more than one channel
  assert_ptr_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ptr_i));

  // R5: outputs in strobe mode are one-hot or empty
  assert_out_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_en_i |-> $onehot0(chan_en_i));

  // R8: leaving strobe mode returns the pointer to idle
  assert_idle_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_en_i |=> ptr_i == '0);

  // R3: no rising edge, no movement
  assert_hold_without_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_en_i && !rise_i) |=> $stable(ptr_i));

  // R3: an edge moves the pointer up by one channel
  assert_step_up_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_en_i && rise_i && ptr_i != '0 && !ptr_i[N-1]) |=> ptr_i == ($past(ptr_i) << 1));

  // R4: an edge on the last channel wraps to channel 0
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_en_i && rise_i && ptr_i[N-1]) |=> ptr_i[0]);

  // R8: the first edge from idle picks channel 0
  assert_first_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_en_i && rise_i && ptr_i == '0) |=> ptr_i[0]);

  // R6: nothing is lit while the delayed PWM level is low
  assert_dark_when_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_en_i && !level_i) |-> chan_en_i == '0);
endmodule

bind led_strobe_sequencer strobe_checker #(.N(NUM_CH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_int_n),
  .strobe_en_i (strobe_en_i),
  .rise_i      (rise),
  .level_i     (pwm_level),
  .ptr_i       (ptr_q),
  .chan_en_i   (chan_en_o)
);

// File: tb/sim_led_strobe_sequencer.sv
`timescale 1ns/1ps
module sim_led_strobe_sequencer;
  localparam int N = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         strobe_en;
  logic         pwm;
  logic [N-1:0] normal_en;
  logic [N-1:0] chan_en;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural reference state
  int    rcnt = 0;
  bit    pipe[$];
  bit    m_level = 0;
  int    m_idx = -1;

  always #2.5 clk = ~clk;

  led_strobe_sequencer u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .strobe_en_i (strobe_en),
    .pwm_i       (pwm),
    .normal_en_i (normal_en),
    .chan_en_o   (chan_en)
  );

  function automatic logic [N-1:0] expected();
    logic [N-1:0] v = '0;
    if (!strobe_en) return normal_en;
    if (m_idx >= 0 && m_level) v[m_idx] = 1'b1;
    return v;
  endfunction

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: chan_en=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      rcnt = 0; pipe = {1'b0, 1'b0}; m_level = 0; m_idx = -1;
    end else if (rcnt < 2) begin
      rcnt++;
    end else begin
      bit synced;
      bit rise;
      synced = pipe[1];
      rise   = synced && !m_level;
      if (!strobe_en)  m_idx = -1;
      else if (rise)   m_idx = (m_idx < 0) ? 0 : (m_idx + 1) % N;
      m_level = synced;
      pipe.pop_back();
      pipe.push_front(pwm);
    end
    #1.25;
    if (!done) check(cur_req, chan_en, expected());
  end

  task automatic pulse(int hi, int lo);
    @(negedge clk); pwm = 1'b1;
    repeat (hi) @(negedge clk);
    pwm = 1'b0;
    repeat (lo - 1) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    pipe = {1'b0, 1'b0};
    rst_n = 1'b0; strobe_en = 1'b0; pwm = 1'b0; normal_en = '0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: pass-through with PWM activity present
    cur_req = "R7";
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      normal_en = N'($urandom);
      pwm = i[1];
    end
    pwm = 1'b0;
    repeat (4) @(negedge clk);

    // R1: strobe mode on, no edge yet -> dark
    cur_req = "R1";
    strobe_en = 1'b1;
    normal_en = '1;
    repeat (6) @(negedge clk);
    check("R1", chan_en, '0);

    // R2: latency of the first lit cycle
    cur_req = "R2";
    pwm = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R2", chan_en, '0);
    @(posedge clk); #1;
    check("R2", chan_en, 10'b0000000001);
    @(negedge clk); pwm = 1'b0;
    repeat (5) @(negedge clk);

    // R3/R5: walk through the channels with varied widths
    cur_req = "R3";
    for (int k = 1; k < N; k++) pulse(1 + (k % 4), 2 + (k % 3));

    // R4: wrap past the last channel, twice round
    cur_req = "R4";
    for (int k = 0; k < N + 3; k++) pulse(2, 3);

    // R6: long on-times and single-cycle pulses
    cur_req = "R6";
    pulse(12, 4);
    pulse(1, 2);
    pulse(1, 6);
    pulse(7, 1);
    repeat (5) @(negedge clk);

    // R5: alternating widths stress
    cur_req = "R5";
    for (int k = 0; k < 8; k++) pulse(1 + k, 1 + (k % 2) + 1);

    // R8: exit mid-pulse, re-enter, first edge is channel 0
    cur_req = "R8";
    @(negedge clk); pwm = 1'b1;
    repeat (4) @(negedge clk);
    strobe_en = 1'b0; normal_en = 10'b1010010110;
    repeat (3) @(negedge clk);
    pwm = 1'b0;
    repeat (4) @(negedge clk);
    strobe_en = 1'b1;
    repeat (3) @(negedge clk);
    pulse(3, 3);
    @(posedge clk); #1;
    check("R8", chan_en, '0);

    // R8: edge coinciding with mode entry
    strobe_en = 1'b0;
    repeat (4) @(negedge clk);
    pwm = 1'b1;
    @(negedge clk); @(negedge clk);
    strobe_en = 1'b1;
    repeat (4) @(negedge clk);
    pwm = 1'b0;
    repeat (4) @(negedge clk);
    pulse(2, 4);

    // R8: edge coinciding with mode exit is dropped
    pwm = 1'b1;
    @(negedge clk); @(negedge clk);
    strobe_en = 1'b0;
    @(negedge clk);
    strobe_en = 1'b1;
    repeat (3) @(negedge clk);
    pwm = 1'b0;
    repeat (3) @(negedge clk);
    pulse(2, 4);

    // R1: reset in the middle of strobe activity
    cur_req = "R1";
    @(negedge clk); pwm = 1'b1;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); pwm = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1", chan_en, '0);
    pulse(2, 4);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule